// File: doc/BRIEF.md
# Dual-Counter Event Monitor

This block gives a processor two 32-bit event counters that share one control register. Software sees both counters as a single 64-bit word, with the upper counter in the high half and the lower counter in the low half. The control word has a separate event-code field for each counter. It also has three privilege-context enables, one each for user, supervisor and hypervisor. These enables apply to both counters at the same time.

On every clock the unit receives a vector of single-cycle event strobes and the current privilege context. A counter advances by one when two conditions hold in that cycle: the strobe its code selects is high, and the enable for the current context is set. Because the enables are shared, the only way to park one counter on its own is to give it the idle code. No strobe is ever tied to that code.

A counter that steps from all ones to zero sets a sticky overflow status bit. Software clears that bit by writing one to it. Each status bit is gated by its own interrupt enable, and the gated bits are combined into the interrupt line. Software can preload a counter with the two's complement of a sampling period, so that the interrupt arrives after exactly that many events.

Top module: `evtmon_top`

## Requirements
- R1: After reset the control word, both counters and both status bits read zero, and `irq_o` is low.
- R2: Register address 1 is the counter word. Bits 63:32 hold the upper counter and bits 31:0 hold the lower counter. A write to it loads both counters, and a read returns both.
- R3: Address 0 is the control word. The 12-bit code at control bits 17:6 drives the lower counter, and the 12-bit code at bits 30:19 drives the upper counter. A code below the strobe count selects the strobe bit with that index. Any other code never fires.
- R4: Contexts are encoded 0 = user, 1 = supervisor, 2 = hypervisor and 3 = none. They are gated by control bits 4, 5 and 3 respectively. Context 3 never counts.
- R5: When control bits 5:3 are all clear, neither counter changes, whatever strobes arrive.
- R6: A counter whose code is 0x220 holds its value while the other counter keeps counting.
- R7: Address 2 is status. Bit 0 belongs to the lower counter and bit 1 to the upper counter. A status bit is set only when its counter counts from 0xFFFFFFFF to 0. Preloads and other counts leave it unchanged.
- R8: When a counter-word write and a count fall in the same cycle, the written value is kept and no overflow is flagged.
- R9: Writing status clears each bit written as one and leaves each bit written as zero unchanged.
- R10: `irq_o` is high exactly when (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1).
- R11: A counter preloaded with 2^32 − N reaches zero, and sets its status bit, on its N-th counted event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 16 | Per-cycle event strobes |
| ctx_i | input | 2 | Current privilege context (0 user, 1 supervisor, 2 hypervisor, 3 none) |
| reg_addr_i | input | 2 | Register select: 0 control, 1 counters, 2 status |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Read data for the selected register, combinational |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A wrong event-code decode or a wrong context gate shows at the counter word within one clock. It appears as a count that moves when it should hold, or holds when it should move. A broken wrap detector shows at the status word and at `irq_o` on the edge of the wrap itself. This is checked both one event early and exactly on the wrap. A wrong write-versus-count priority is exposed by a preload that collides with a strobe while the counter holds all ones. In that case both the counter value and the status word read wrong in the very next cycle.

// File: rtl/evtmon_pkg.sv
package evtmon_pkg;

    typedef enum logic [1:0] {
        CTX_USER = 2'd0,
        CTX_SUPV = 2'd1,
        CTX_HYPV = 2'd2,
        CTX_NONE = 2'd3
    } ctx_e;

    typedef enum logic [1:0] {
        ADDR_CTL = 2'd0,
        ADDR_CNT = 2'd1,
        ADDR_STS = 2'd2,
        ADDR_RSV = 2'd3
    } addr_e;

    localparam logic [11:0] IDLE_CODE_DEF = 12'h220;

    localparam int EN_HYPV_BIT = 3;
    localparam int EN_USER_BIT = 4;
    localparam int EN_SUPV_BIT = 5;

endpackage

// File: rtl/evtmon_ctx_gate.sv
module evtmon_ctx_gate
    import evtmon_pkg::*;
(
    input  ctx_e ctx_i,
    input  logic en_user_i,
    input  logic en_supv_i,
    input  logic en_hypv_i,
    output logic count_ok_o
);

    always_comb begin
        unique case (ctx_i)
            CTX_USER: count_ok_o = en_user_i;
            CTX_SUPV: count_ok_o = en_supv_i;
            CTX_HYPV: count_ok_o = en_hypv_i;
            default:  count_ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/evtmon_lane.sv
module evtmon_lane #(
    parameter int          CNT_W     = 32,
    parameter int          EVT_W     = 12,
    parameter int          N_EVT     = 16,
    parameter logic [11:0] IDLE_CODE = 12'h220
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_i,
    input  logic [EVT_W-1:0] code_i,
    input  logic             en_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam int               SEL_W   = $clog2(N_EVT);
    localparam logic [EVT_W-1:0] N_EVT_C = EVT_W'(N_EVT);
    localparam logic [EVT_W-1:0] IDLE_C  = EVT_W'(IDLE_CODE);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        hit    = en_i && (code_i != IDLE_C) && (code_i < N_EVT_C)
                 && evt_i[code_i[SEL_W-1:0]];
        if (wr_i) begin
            st_d.cnt = wr_val_i;
        end else if (hit) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap_o   = (st_q.cnt == '1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));

    // R8
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_o == $past(wr_val_i)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == IDLE_C && !wr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/evtmon_top.sv
module evtmon_top
    import evtmon_pkg::*;
#(
    parameter int          CNT_W     = 32,
    parameter int          EVT_W     = 12,
    parameter int          N_EVT     = 16,
    parameter int          LO_SHIFT  = 6,
    parameter int          UP_SHIFT  = 19,
    parameter logic [11:0] IDLE_CODE = IDLE_CODE_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_EVT-1:0]   evt_i,
    input  logic [1:0]         ctx_i,
    input  logic [1:0]         reg_addr_i,
    input  logic               wr_en_i,
    input  logic [2*CNT_W-1:0] wr_data_i,
    output logic [2*CNT_W-1:0] rd_data_o,
    output logic               irq_o
);

    localparam int REG_W  = 2*CNT_W;
    localparam int CTL_W  = UP_SHIFT + EVT_W;
    localparam int N_LANE = 2;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [N_LANE-1:0] sts;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [N_LANE-1:0] wrap;
    logic [REG_W-1:0]  cnt_all;
    logic              count_ok;
    logic              wr_ctl, wr_cnt, wr_sts;
    addr_e             addr;

    assign addr   = addr_e'(reg_addr_i);
    assign wr_ctl = wr_en_i && (addr == ADDR_CTL);
    assign wr_cnt = wr_en_i && (addr == ADDR_CNT);
    assign wr_sts = wr_en_i && (addr == ADDR_STS);

    evtmon_ctx_gate u_gate (
        .ctx_i      (ctx_e'(ctx_i)),
        .en_user_i  (st_q.ctl[EN_USER_BIT]),
        .en_supv_i  (st_q.ctl[EN_SUPV_BIT]),
        .en_hypv_i  (st_q.ctl[EN_HYPV_BIT]),
        .count_ok_o (count_ok)
    );

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        localparam int SH = (g == 0) ? LO_SHIFT : UP_SHIFT;
        evtmon_lane #(
            .CNT_W     (CNT_W),
            .EVT_W     (EVT_W),
            .N_EVT     (N_EVT),
            .IDLE_CODE (IDLE_CODE)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_i),
            .code_i   (st_q.ctl[SH +: EVT_W]),
            .en_i     (count_ok),
            .wr_i     (wr_cnt),
            .wr_val_i (wr_data_i[g*CNT_W +: CNT_W]),
            .cnt_o    (cnt_all[g*CNT_W +: CNT_W]),
            .wrap_o   (wrap[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctl) st_d.ctl = wr_data_i[CTL_W-1:0];
        if (wr_sts) st_d.sts = st_q.sts & ~wr_data_i[N_LANE-1:0];
        st_d.sts = st_d.sts | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (addr)
            ADDR_CTL: rd_data_o = {{(REG_W-CTL_W){1'b0}}, st_q.ctl};
            ADDR_CNT: rd_data_o = cnt_all;
            ADDR_STS: rd_data_o = {{(REG_W-N_LANE){1'b0}}, st_q.sts};
            default:  rd_data_o = '0;
        endcase
    end

    assign irq_o = |(st_q.sts & st_q.ctl[N_LANE-1:0]);

    // R4
    no_ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_i == CTX_NONE && !wr_cnt) |=> $stable(cnt_all));

    // R5
    all_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl[EN_SUPV_BIT:EN_HYPV_BIT] == 3'b000 && !wr_cnt) |=> $stable(cnt_all));

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl[N_LANE-1:0] == '0) |-> !irq_o);

    // R9
    sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wr_data_i[0] && !wrap[0]) |=> (rd_data_o[0] == 1'b0 || addr != ADDR_STS));

endmodule

// File: tb/sim_evtmon_top.sv
module sim_evtmon_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_i = '0;
    logic [1:0]  ctx_i = '0;
    logic [1:0]  reg_addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [63:0] wr_data_i = '0;
    logic [63:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    evtmon_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .ctx_i      (ctx_i),
        .reg_addr_i (reg_addr_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rd_data_o  (rd_data_o),
        .irq_o      (irq_o)
    );

    typedef struct packed {
        logic [31:0] ctl;
        logic [63:0] pre;
        logic [1:0]  ctx;
        logic [15:0] evt;
        logic [7:0]  n;
        logic [63:0] exp;
    } vec_t;

    // Control: upper code <<19, lower code <<6, hyp bit3, user bit4, sup bit5
    localparam vec_t VECS [10] = '{
        '{32'h0028_0090, 64'h0,                     2'd0, 16'h0024, 8'd10, 64'h0000_000A_0000_000A}, // R3 R4 user
        '{32'h0028_0090, 64'h0000_0064_0000_0005,   2'd0, 16'h0004, 8'd7,  64'h0000_0064_0000_000C}, // R3 one strobe
        '{32'h0028_0090, 64'h0000_0003_0000_0004,   2'd1, 16'h0024, 8'd8,  64'h0000_0003_0000_0004}, // R4 sup disabled
        '{32'h0028_00A0, 64'h0,                     2'd1, 16'h0024, 8'd4,  64'h0000_0004_0000_0004}, // R4 sup
        '{32'h0028_0088, 64'h0,                     2'd2, 16'h0024, 8'd3,  64'h0000_0003_0000_0003}, // R4 hyp
        '{32'h0028_00B8, 64'h0000_0001_0000_0001,   2'd3, 16'h0024, 8'd5,  64'h0000_0001_0000_0001}, // R4 none
        '{32'h1100_0090, 64'h0000_0032_0000_0000,   2'd0, 16'hFFFF, 8'd6,  64'h0000_0032_0000_0006}, // R6 upper idle
        '{32'h0028_8810, 64'h0000_0000_0000_0009,   2'd0, 16'hFFFF, 8'd6,  64'h0000_0006_0000_0009}, // R6 lower idle
        '{32'h0028_0080, 64'h0000_0007_0000_0007,   2'd0, 16'h0024, 8'd5,  64'h0000_0007_0000_0007}, // R5 all off
        '{32'h0028_0090, 64'h0000_0000_0000_0000,   2'd0, 16'h0003, 8'd4,  64'h0000_0000_0000_0000}  // R3 unselected strobes
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [63:0] d);
        reg_addr_i = a;
        wr_data_i  = d;
        wr_en_i    = 1'b1;
        @(negedge clk);
        wr_en_i    = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [63:0] d);
        reg_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic run(input logic [1:0] c, input logic [15:0] e, input int n);
        ctx_i = c;
        evt_i = e;
        repeat (n) @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(2'd0, r); check("R1 ctl", r, 64'h0);
        rd_reg(2'd1, r); check("R1 cnt", r, 64'h0);
        rd_reg(2'd2, r); check("R1 sts", r, 64'h0);
        check("R1 irq", {63'b0, irq_o}, 64'h0);

        for (int i = 0; i < 10; i++) begin
            wr_reg(2'd0, {32'h0, VECS[i].ctl});
            wr_reg(2'd1, VECS[i].pre);
            run(VECS[i].ctx, VECS[i].evt, int'(VECS[i].n));
            rd_reg(2'd1, r);
            check($sformatf("R2 R3 R4 R5 R6 vector %0d", i), r, VECS[i].exp);
        end
        wr_reg(2'd2, 64'h3);

        // R11 R7 lower preload -3, lower code 1, upper idle, irq en bit0
        wr_reg(2'd0, 64'h1100_0051);
        wr_reg(2'd1, 64'h0000_0000_FFFF_FFFD);
        run(2'd0, 16'h0002, 2);
        rd_reg(2'd1, r); check("R11 before wrap cnt", r, 64'h0000_0000_FFFF_FFFF);
        rd_reg(2'd2, r); check("R7 no status before wrap", r, 64'h0);
        check("R10 irq low before wrap", {63'b0, irq_o}, 64'h0);
        run(2'd0, 16'h0002, 1);
        rd_reg(2'd1, r); check("R11 wrap cnt", r, 64'h0);
        rd_reg(2'd2, r); check("R7 status on wrap", r, 64'h1);
        check("R10 irq on wrap", {63'b0, irq_o}, 64'h1);

        // R10 masking
        wr_reg(2'd0, 64'h1100_0052);
        check("R10 irq masked", {63'b0, irq_o}, 64'h0);
        wr_reg(2'd0, 64'h1100_0051);
        check("R10 irq unmasked", {63'b0, irq_o}, 64'h1);

        // R9 write-one-to-clear
        wr_reg(2'd2, 64'h0);
        rd_reg(2'd2, r); check("R9 zero write keeps", r, 64'h1);
        wr_reg(2'd2, 64'h1);
        rd_reg(2'd2, r); check("R9 one write clears", r, 64'h0);
        check("R9 irq after clear", {63'b0, irq_o}, 64'h0);

        // R8 write and count collide at all ones
        wr_reg(2'd1, 64'h0000_0000_FFFF_FFFF);
        ctx_i = 2'd0;
        evt_i = 16'h0002;
        wr_reg(2'd1, 64'h0000_0000_0000_1234);
        evt_i = '0;
        rd_reg(2'd1, r); check("R8 write wins", r, 64'h0000_0000_0000_1234);
        rd_reg(2'd2, r); check("R8 no overflow", r, 64'h0);

        // R7 upper wrap, lower idle
        wr_reg(2'd0, 64'h0028_8813);
        wr_reg(2'd1, 64'hFFFF_FFFF_0000_0055);
        run(2'd0, 16'h0020, 1);
        rd_reg(2'd1, r); check("R7 upper wrap cnt", r, 64'h0000_0000_0000_0055);
        rd_reg(2'd2, r); check("R7 upper status bit1", r, 64'h2);
        check("R10 irq upper", {63'b0, irq_o}, 64'h1);
        wr_reg(2'd2, 64'h2);

        // R2 full-word write and readback, both idle
        wr_reg(2'd0, 64'h1100_8810);
        wr_reg(2'd1, 64'hDEAD_BEEF_0123_4567);
        run(2'd0, 16'hFFFF, 3);
        rd_reg(2'd1, r); check("R2 readback", r, 64'hDEAD_BEEF_0123_4567);
        rd_reg(2'd0, r); check("R3 ctl readback", r, 64'h1100_8810);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule